// File: doc/BRIEF.md
# Mixed-Signedness Fractional Multiplier

This unit multiplies two 8-bit operands for a small microcontroller datapath. A 3-bit mode picks how each operand is read (both unsigned, both signed, or signed first with unsigned second). It also picks whether the product is returned as an integer or in fractional form, which is the product shifted left by one bit. The 16-bit result comes out as a high byte and a low byte, ready for a register pair. Two flags come with it: zero and carry.

Operands enter on a valid/ready handshake. `in_ready` is high only while the unit is idle. Once an operation has been accepted, `in_ready` stays low until its result has been taken, so at most one operation is in flight. The result appears on the second rising edge after acceptance. It then waits under `out_valid` until the consumer raises `out_ready`. While the consumer stalls, the result and the flags hold unchanged.

Top module: `mfu_top`

## Requirements
- R1: `mode[1:0]` = 00 reads both operands as unsigned; the result is `op_a*op_b` modulo 2^16.
- R2: `mode[1:0]` = 01 reads both operands as two's complement; the result is the signed product modulo 2^16.
- R3: `mode[1:0]` = 10 sign-extends `op_a` only and zero-extends `op_b`.
- R4: `mode[2]` = 1 selects fractional form: the result is the 16-bit product shifted left by one bit, bit 0 is 0, and the old bit 15 is dropped.
- R5: `flag_c` equals bit 15 of the product before any fractional shift.
- R6: `flag_z` is 1 exactly when the 16-bit result returned is zero.
- R7: `prod_hi` carries result bits 15..8 and `prod_lo` carries bits 7..0.
- R8: an operation accepted on a rising edge (`in_valid` and `in_ready` both high) shows `out_valid` low after that edge and high after the next one.
- R9: `in_ready` is low from the accepting edge until the edge where the result is taken (`out_valid` and `out_ready` both high); `in_valid` and the operands have no effect during that time.
- R10: while `out_valid` is high and `out_ready` is low, `out_valid`, `prod_hi`, `prod_lo`, `flag_z` and `flag_c` hold their values.
- R11: after reset `out_valid` is 0 and `in_ready` is 1.
- R12: `mode[1:0]` = 11 behaves the same as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are offered |
| in_ready | output | 1 | Unit is idle and accepts an operation |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| mode | input | 3 | [1:0] signedness pairing, [2] fractional form |
| out_valid | output | 1 | Result and flags are present |
| out_ready | input | 1 | Consumer takes the result |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Bit 15 of the unshifted product |

## Verification
After the accepting edge the bench samples on the falling edge. There it expects `out_valid` low and `in_ready` low. One edge later, on the next falling edge, it expects the result, the flags and `out_valid` high. During that window it keeps `in_valid` high with altered operands, and checks that the result still matches the accepted operands. It then holds `out_ready` low for a random number of cycles and checks that every output stays fixed. Finally it completes the handshake and checks that `in_ready` returns one falling edge after the taking edge.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
  typedef enum logic [1:0] {
    PAIR_UU  = 2'b00,
    PAIR_SS  = 2'b01,
    PAIR_SU  = 2'b10,
    PAIR_RSV = 2'b11
  } pair_e;
endpackage

// File: rtl/mfu_extend.sv
module mfu_extend #(
  parameter int W = 8
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  mfu_pkg::pair_e     pair,
  output logic signed [W:0]  a_x,
  output logic signed [W:0]  b_x
);
  import mfu_pkg::*;
  logic a_sgn, b_sgn;

  // R3: first operand signed in SS and SU, second only in SS; R12: RSV acts as UU
  always_comb begin
    a_sgn = ((pair == PAIR_SS) || (pair == PAIR_SU)) && a[W-1];
    b_sgn = (pair == PAIR_SS) && b[W-1];
  end

  assign a_x = {a_sgn, a};
  assign b_x = {b_sgn, b};
endmodule

// File: rtl/mfu_flags.sv
module mfu_flags #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic signed [W:0] a_x,
  input  logic signed [W:0] b_x,
  input  logic              frac,
  output logic [PW-1:0]     result,
  output logic              carry,
  output logic              zero
);
  logic signed [PW-1:0] a_w, b_w, raw;

  assign a_w = {{(W-1){a_x[W]}}, a_x};
  assign b_w = {{(W-1){b_x[W]}}, b_x};
  assign raw = a_w * b_w;

  always_comb begin
    carry  = raw[PW-1];                               // R5
    result = frac ? {raw[PW-2:0], 1'b0} : raw;        // R4
    zero   = (result == '0);                          // R6
  end
endmodule

// File: rtl/mfu_core.sv
module mfu_core #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic signed [W:0] a_x,
  input  logic signed [W:0] b_x,
  input  logic              frac,
  input  logic              take,
  output logic              res_v,
  output logic [PW-1:0]     res,
  output logic              res_c,
  output logic              res_z
);
  logic signed [W:0] a_q, b_q;
  logic              frac_q, s1_v, res_frac;
  logic [PW-1:0]     f_res;
  logic              f_c, f_z;

  mfu_flags #(.W(W)) u_flags (
    .a_x(a_q), .b_x(b_q), .frac(frac_q),
    .result(f_res), .carry(f_c), .zero(f_z)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; frac_q <= 1'b0; s1_v <= 1'b0;
    end else begin
      s1_v <= load;
      if (load) begin
        a_q <= a_x; b_q <= b_x; frac_q <= frac;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_v <= 1'b0; res <= '0; res_c <= 1'b0; res_z <= 1'b0; res_frac <= 1'b0;
    end else if (s1_v) begin
      res_v <= 1'b1; res <= f_res; res_c <= f_c; res_z <= f_z; res_frac <= frac_q;
    end else if (take) begin
      res_v <= 1'b0;
    end
  end

  a_r8_second_edge: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> res_v);
  a_r4_frac_lsb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res_frac) |-> (res[0] == 1'b0));
  a_r5_carry_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && !res_frac) |-> (res_c == res[PW-1]));
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && !take) |=> (res_v && $stable(res) && $stable(res_c) && $stable(res_z)));
endmodule

// File: rtl/mfu_top.sv
module mfu_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic         flag_z,
  output logic         flag_c
);
  import mfu_pkg::*;
  localparam int PW = 2 * W;

  logic              busy, accept, take;
  logic signed [W:0] a_x, b_x;
  logic [PW-1:0]     res;
  pair_e             pair;

  assign pair     = pair_e'(mode[1:0]);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign take     = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy <= 1'b0;
    else if (accept) busy <= 1'b1;
    else if (take)   busy <= 1'b0;
  end

  mfu_extend #(.W(W)) u_ext (
    .a(op_a), .b(op_b), .pair(pair), .a_x(a_x), .b_x(b_x)
  );

  mfu_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .a_x(a_x), .b_x(b_x),
    .frac(mode[2]), .take(take), .res_v(out_valid), .res(res),
    .res_c(flag_c), .res_z(flag_z)
  );

  assign prod_hi = res[PW-1:W];   // R7
  assign prod_lo = res[W-1:0];

  a_r9_blocked_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r9_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_z) |-> ({prod_hi, prod_lo} == '0));
endmodule

// File: tb/tb_mfu_top.sv
module tb_mfu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [2:0] mode = '0;
  logic       in_ready, out_valid, flag_z, flag_c;
  logic [7:0] prod_hi, prod_lo;
  int         total = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  mfu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .mode(mode), .out_valid(out_valid),
    .out_ready(out_ready), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model: returns {z, c, result[15:0]}
  function automatic logic [17:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [2:0] m);
    int ai, bi, p;
    logic [15:0] raw, r;
    ai = a; bi = b;
    if ((m[1:0] == 2'b01 || m[1:0] == 2'b10) && a[7]) ai = ai - 256;
    if (m[1:0] == 2'b01 && b[7]) bi = bi - 256;
    p   = ai * bi;
    raw = p[15:0];
    r   = m[2] ? {raw[14:0], 1'b0} : raw;
    return {(r == 16'h0), raw[15], r};
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    if (m[2]) return "R4";
    case (m[1:0])
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] m, input int stall);
    logic [17:0] e;
    e = model(a, b, m);
    @(negedge clk);
    chk("R9 idle ready", in_ready, 1);
    op_a = a; op_b = b; mode = m; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_a = ~a; op_b = b + 8'd1; mode = ~m;   // ignored while busy (R9)
    chk("R8 not yet valid", out_valid, 0);
    chk("R9 ready low after accept", in_ready, 0);
    @(posedge clk); @(negedge clk);
    chk("R8 valid on second edge", out_valid, 1);
    chk({mode_tag(m), " R7 product"}, {prod_hi, prod_lo}, e[15:0]);
    chk("R5 carry", flag_c, e[16]);
    chk("R6 zero", flag_z, e[17]);
    for (int i = 0; i < stall; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 held", {out_valid, flag_z, flag_c, prod_hi, prod_lo}, {1'b1, e[17:0]});
      chk("R9 still blocked", in_ready, 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    chk("R9 released after take", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    #1;
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset in_ready", in_ready, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // directed corners
    run_op(8'hFF, 8'hFF, 3'b000, 0);   // R1 0xFE01, c=1
    run_op(8'hFF, 8'hFF, 3'b100, 1);   // R4 0xFC02
    run_op(8'h80, 8'h80, 3'b001, 2);   // R2 0x4000
    run_op(8'h80, 8'h80, 3'b101, 0);   // R4 0x8000, c=0
    run_op(8'hFF, 8'hFF, 3'b010, 0);   // R3 0xFF01
    run_op(8'h7F, 8'hFF, 3'b010, 0);   // R3 0x7E81
    run_op(8'h00, 8'h9C, 3'b001, 0);   // R6 zero
    run_op(8'h00, 8'h9C, 3'b111, 1);   // R6 zero in frac
    run_op(8'hC3, 8'hA5, 3'b011, 0);   // R12 same as unsigned
    for (int n = 0; n < 300; n++)
      run_op(8'($urandom), 8'($urandom), 3'($urandom), int'($urandom % 4));
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule